// File: doc/BRIEF.md
# Serially Loaded Eight-Channel DAC Code Register Controller

This block is the digital front end of an eight-channel voltage DAC. A host drives a three-wire serial port: a bit clock, a data line and an active-low select. While the select is low, each rising edge of the bit clock moves one data bit into a 16-bit shift register. When the select returns high, the word in that register is executed as a command. The word holds a 4-bit command address, sent first, then the DAC code, most significant bit first, then filler bits. The command either writes one channel, writes all channels, leaves the channels alone, or puts the converter to sleep. The serial pins are sampled in a faster system clock domain through two-flop synchronizers, and edges are detected there.

The most significant bit of the shift register drives a serial output, so a bit put on the data line comes out 16 bit-clock edges later. Several devices can be chained output-to-input and loaded with one select pulse. An asynchronous clear input zeroes the shift register and every code register. The code width is a parameter, 8 or 10 bits; the filler field fills the rest of the 16-bit word. The outputs are the eight code registers, a sleep flag, and a one-cycle update strobe for each channel.

The control is a three-state machine. ST_IDLE waits with the select high and moves to ST_SHIFT when the synchronized select goes low. ST_SHIFT shifts on each detected bit-clock rise and moves to ST_EXEC when the synchronized select goes high again. ST_EXEC lasts one cycle: it applies the command and then returns to ST_IDLE.

Top module: `octal_dac_ctrl`

## Requirements
- R1: After reset, every code register reads zero, the sleep flag is 0, the serial output is 0 and no update strobe is set.
- R2: With the select low, each rising bit-clock edge shifts the data bit into the register. The first 4 bits form the address (bits 15:12). The next CODE_W bits form the code, MSB first (bits 11:12-CODE_W). The remaining bits are ignored.
- R3: A rising edge on the select executes the held word. Address n, for n from 1 to 8, loads channel n-1 (channel 0 is code_o[CODE_W-1:0]).
- R4: Address 15 loads the same code into all eight channels.
- R5: Address 0 and addresses 9 to 13 change no code register and clear the sleep flag.
- R6: Address 14 sets the sleep flag, ignores the code field and keeps every code register. Any later command to another address clears the flag.
- R7: The serial output equals the data bit that was shifted in 16 rising bit-clock edges earlier. In a chained 32-bit frame, the first word passes through and the last 16 bits are executed.
- R8: A low level on the clear input asynchronously zeroes every code register, the shift register and the sleep flag.
- R9: Each written channel raises its update strobe for exactly one system clock cycle. That is the same cycle in which its new code first appears. A broadcast load raises all eight strobes.
- R10: Bit-clock edges while the select is high shift nothing. A later frame with no clock edges re-executes the word that was already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_n_i | input | 1 | Active-low asynchronous clear of the shift register and the code registers |
| sck_i | input | 1 | Serial bit clock (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| csn_i | input | 1 | Active-low select; its rising edge executes the command |
| sdo_o | output | 1 | Serial data out, delayed by 16 bit-clock edges, for chaining |
| code_o | output | CH_N*CODE_W | Code registers; channel i is at [i*CODE_W +: CODE_W] |
| upd_o | output | CH_N | Per-channel one-cycle update strobe |
| sleep_o | output | 1 | Sleep flag |

## Verification
Each of the eight single-channel addresses is loaded with a distinct code, including all-zeros and all-ones. This shows whether the address decode maps each address to the right channel and whether the code field is taken MSB first. The no-change addresses and the sleep address are then sent with non-zero codes, and the registers and strobes must stay quiet. Wake by a no-change address and wake by a load are tried separately, which tells apart an exit from sleep from a register write. A 32-bit chained frame checks the serial output bit by bit and shows that only the trailing word executes. Stray bit clocks with the select high, followed by an empty frame, show whether shifting was truly gated. A clear pulse shows whether both the codes and the shift register were zeroed.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OP_SLEEP = 4'hE;
    localparam logic [ADDR_W-1:0] OP_ALL   = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EXEC  = 2'd2
    } dacc_state_e;
endpackage

// File: rtl/dacc_sync.sv
module dacc_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dacc_shift.sv
module dacc_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              shift_en_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] word_o,
    output logic              sdo_o
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)         sr_q <= '0;
        else if (shift_en_i) sr_q <= {sr_q[WORD_W-2:0], din_i};
    end

    assign word_o = sr_q;
    assign sdo_o  = sr_q[WORD_W-1];
endmodule

// File: rtl/dacc_fsm.sv
module dacc_fsm
    import dacc_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic cs_i,
    input  logic sck_rise_i,
    output logic shift_en_o,
    output logic exec_o
);
    dacc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_i) state_d = ST_SHIFT;
            ST_SHIFT: if (cs_i)  state_d = ST_EXEC;
            ST_EXEC:             state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en_o = 1'b0;
        exec_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:  shift_en_o = sck_rise_i && !cs_i;
            ST_SHIFT: shift_en_o = sck_rise_i && !cs_i;
            ST_EXEC:  exec_o     = 1'b1;
            default:  ;
        endcase
    end

    // R3
    exec_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
        exec_o |=> !exec_o);
    // R3
    exec_after_cs_chk: assert property (@(posedge clk) disable iff (!arst_n)
        exec_o |-> $past(cs_i));
endmodule

// File: rtl/dacc_regs.sv
module dacc_regs
    import dacc_pkg::*;
#(
    parameter int CH_N = 8,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     arst_n,
    input  logic                     exec_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic [CH_N*CODE_W-1:0]   code_o,
    output logic [CH_N-1:0]          upd_o,
    output logic                     sleep_o
);
    logic [CH_N-1:0] hit;

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(i + 1);
        logic [CODE_W-1:0] code_q;
        logic              upd_q;

        assign hit[i] = exec_i && (addr_i == CH_ADDR || addr_i == OP_ALL);

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                code_q <= '0;
                upd_q  <= 1'b0;
            end else begin
                upd_q <= hit[i];
                if (hit[i]) code_q <= code_i;
            end
        end

        assign code_o[i*CODE_W +: CODE_W] = code_q;
        assign upd_o[i] = upd_q;
    end

    logic sleep_q;
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     sleep_q <= 1'b0;
        else if (exec_i) sleep_q <= (addr_i == OP_SLEEP);
    end
    assign sleep_o = sleep_q;

    // R9
    upd_shape_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (upd_o != '0) |-> ($countones(upd_o) == 1 || (&upd_o)));
    // R6
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sleep_o) |-> (upd_o == '0));
    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !$past(exec_i) |-> $stable(code_o));
    // R9
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (upd_o != '0) |=> ((upd_o & $past(upd_o)) == '0 || $past(exec_i)));
endmodule

// File: rtl/octal_dac_ctrl.sv
module octal_dac_ctrl
    import dacc_pkg::*;
#(
    parameter int CH_N = 8,
    parameter int CODE_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_n_i,
    input  logic                   sck_i,
    input  logic                   sdi_i,
    input  logic                   csn_i,
    output logic                   sdo_o,
    output logic [CH_N*CODE_W-1:0] code_o,
    output logic [CH_N-1:0]        upd_o,
    output logic                   sleep_o
);
    localparam int CODE_MSB = WORD_W - ADDR_W - 1;

    logic arst_n;
    assign arst_n = rst_n && clr_n_i;

    logic [2:0] pins_s;
    dacc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .arst_n(arst_n),
        .d_i({csn_i, sdi_i, sck_i}), .q_o(pins_s)
    );

    logic cs_s, din_s, sck_s, sck_d, sck_rise;
    assign cs_s  = pins_s[2];
    assign din_s = pins_s[1];
    assign sck_s = pins_s[0];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sck_d <= 1'b0;
        else         sck_d <= sck_s;
    end
    assign sck_rise = sck_s && !sck_d;

    logic shift_en, exec;
    dacc_fsm u_fsm (
        .clk(clk), .arst_n(arst_n), .cs_i(cs_s), .sck_rise_i(sck_rise),
        .shift_en_o(shift_en), .exec_o(exec)
    );

    logic [WORD_W-1:0] word;
    dacc_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .arst_n(arst_n), .shift_en_i(shift_en), .din_i(din_s),
        .word_o(word), .sdo_o(sdo_o)
    );

    dacc_regs #(.CH_N(CH_N), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .arst_n(arst_n), .exec_i(exec),
        .addr_i(word[WORD_W-1 -: ADDR_W]),
        .code_i(word[CODE_MSB -: CODE_W]),
        .code_o(code_o), .upd_o(upd_o), .sleep_o(sleep_o)
    );

    // R10
    idle_noshift_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cs_s |=> $stable(word));
    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!cs_s && sck_rise) |=> (word[0] == $past(din_s)));
endmodule

// File: tb/octal_dac_ctrl_tb_top.sv
`timescale 1ns/1ps
module octal_dac_ctrl_tb_top;
    localparam int CH_N = 8;
    localparam int CODE_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic sck = 1'b0, sdi = 1'b0, csn = 1'b1;
    logic sdo, sleep;
    logic [CH_N*CODE_W-1:0] code;
    logic [CH_N-1:0] upd;

    always #5 clk = ~clk;

    octal_dac_ctrl #(.CH_N(CH_N), .CODE_W(CODE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n), .sck_i(sck), .sdi_i(sdi),
        .csn_i(csn), .sdo_o(sdo), .code_o(code), .upd_o(upd), .sleep_o(sleep)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [11:0] exp_q [$];
    logic [CODE_W-1:0] mdl [CH_N];
    logic mdl_sleep = 1'b0;
    logic [15:0] sr_mdl = '0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard of update strobes
    always @(negedge clk) begin
        if (rst_n && clr_n && upd != '0) begin
            for (int i = 0; i < CH_N; i++) begin
                if (upd[i]) begin
                    if (exp_q.size() == 0) begin
                        chk("R9 unexpected strobe", i, 255);
                    end else begin
                        logic [11:0] it;
                        it = exp_q.pop_front();
                        chk("R9 strobe channel", i, int'(it[11:8]));
                        chk("R3 code at strobe", int'(code[i*CODE_W +: CODE_W]), int'(it[7:0]));
                    end
                end
            end
        end
    end

    task automatic exec_model(logic [15:0] w);
        logic [3:0] a;
        logic [7:0] c;
        a = w[15:12];
        c = w[11:4];
        if (a >= 4'd1 && a <= 4'd8) begin
            mdl[a-1] = c;
            exp_q.push_back({a - 4'd1, c});
        end else if (a == 4'hF) begin
            for (int i = 0; i < CH_N; i++) begin
                mdl[i] = c;
                exp_q.push_back({4'(i), c});
            end
        end
        mdl_sleep = (a == 4'hE);
    endtask

    task automatic compare_all(string req);
        for (int i = 0; i < CH_N; i++)
            chk(req, int'(code[i*CODE_W +: CODE_W]), int'(mdl[i]));
        chk({req, " sleep"}, int'(sleep), int'(mdl_sleep));
    endtask

    task automatic shift_bit(logic b);
        sdi = b;
        wait_n(4);
        chk("R7 serial out", int'(sdo), int'(sr_mdl[15]));
        sck = 1'b1;
        sr_mdl = {sr_mdl[14:0], b};
        wait_n(4);
        sck = 1'b0;
        wait_n(4);
    endtask

    task automatic frame(logic [31:0] bits, int n, string req);
        csn = 1'b0;
        wait_n(6);
        for (int k = n - 1; k >= 0; k--) shift_bit(bits[k]);
        wait_n(4);
        csn = 1'b1;
        exec_model(sr_mdl);
        wait_n(12);
        compare_all(req);
    endtask

    task automatic send(logic [3:0] a, logic [7:0] c, string req);
        frame({16'h0, a, c, 4'hA}, 16, req);
    endtask

    initial begin
        wait_n(3);
        for (int i = 0; i < CH_N; i++) mdl[i] = '0;
        // R1 reset state
        chk("R1 codes", int'(code != '0), 0);
        chk("R1 sleep", int'(sleep), 0);
        chk("R1 sdo", int'(sdo), 0);
        chk("R1 strobes", int'(upd), 0);
        rst_n = 1'b1;
        wait_n(4);

        // R3 R2 each channel, extremes included
        send(4'd1, 8'h00, "R3 ch0");
        send(4'd2, 8'hFF, "R3 ch1");
        for (int i = 3; i <= 8; i++) send(4'(i), 8'(i * 8'h23 + 8'h01), "R3 chn");

        // R5 no-change addresses
        send(4'd0, 8'h5A, "R5 addr0");
        for (int i = 9; i <= 13; i++) send(4'(i), 8'hC3, "R5 nochange");

        // R4 broadcast
        send(4'hF, 8'hA5, "R4 all");
        send(4'd3, 8'h3C, "R3 ch2");

        // R6 sleep, code ignored, wake by no-change then by load
        send(4'hE, 8'hFF, "R6 sleep");
        send(4'd9, 8'h11, "R6 wake nochange");
        send(4'hE, 8'h00, "R6 sleep again");
        send(4'd5, 8'h81, "R6 wake load");

        // R7 chained 32-bit frame: first word passes, second executes
        frame({4'd1, 8'h77, 4'h0, 4'd2, 8'h99, 4'h5}, 32, "R7 chain");
        chk("R7 passthrough kept ch0", int'(code[0 +: CODE_W]), int'(mdl[0]));

        // R10 stray clocks with select high, then an empty frame
        sdi = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(4);
        end
        chk("R10 no shift while high", int'(sdo), int'(sr_mdl[15]));
        frame('0, 0, "R10 re-exec");

        // R8 asynchronous clear
        #2 clr_n = 1'b0;
        #3;
        chk("R8 codes async", int'(code != '0), 0);
        for (int i = 0; i < CH_N; i++) mdl[i] = '0;
        mdl_sleep = 1'b0;
        sr_mdl = '0;
        wait_n(3);
        clr_n = 1'b1;
        wait_n(4);
        compare_all("R8 after clear");
        chk("R8 shift cleared", int'(sdo), 0);
        frame('0, 0, "R8 empty frame");
        send(4'hE, 8'h10, "R8 sleep after");
        send(4'hF, 8'hFF, "R4 all ones");

        wait_n(10);
        chk("R9 all strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule